// File: doc/BRIEF.md
# Execute-Stage ALU with Operation Decoder

This block is the arithmetic unit of the execute stage in a small pipelined RISC core. A 2-bit operation class from the main control and the 6-bit function field of a register-type instruction are decoded into a 3-bit internal select. That select drives a 32-bit ALU, which can compute bitwise AND, bitwise OR, addition, subtraction, and a signed set-on-less-than.

The result, a zero flag and an invalid flag are registered, so they appear one clock after the inputs. A synchronous active-high reset clears them.

Any combination that names no real operation is turned into a reserved select code. This covers the reserved class value 3 and every unlisted function code. The ALU rejects reserved codes: it forces the result to zero and raises the invalid flag. It never falls back to some default operation.

Top module: `exu_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs become `res_q` = 0, `zero_q` = 1 and `invalid_q` = 0.
- R2: With `alu_class` = 2'b00, the next result is `opa + opb` modulo 2^32, whatever the value of `func`.
- R3: With `alu_class` = 2'b01, the next result is `opa - opb` modulo 2^32, whatever the value of `func`.
- R4: With `alu_class` = 2'b10, `func` = 6'b100000 selects addition and `func` = 6'b100010 selects subtraction.
- R5: With `alu_class` = 2'b10, `func` = 6'b100100 selects bitwise AND and `func` = 6'b100101 selects bitwise OR.
- R6: With `alu_class` = 2'b10 and `func` = 6'b101010, the result is 1 in bit 0 when `opa` < `opb` as signed two's-complement values, and 0 otherwise. All upper bits of the result are 0.
- R7: With `alu_class` = 2'b11, whatever the value of `func`, the next outputs are `invalid_q` = 1, `res_q` = 0 and `zero_q` = 0.
- R8: With `alu_class` = 2'b10 and a `func` value outside the five listed codes, the next outputs are `invalid_q` = 1, `res_q` = 0 and `zero_q` = 0.
- R9: For a valid operation, `zero_q` is 1 exactly when the 32-bit result is zero, including results that wrap around.
- R10: Outputs change only at a rising clock edge and reflect the inputs present at that edge (latency of one cycle).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_class | input | 2 | Operation class from main control |
| func | input | 6 | Function field of the instruction |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| res_q | output | 32 | Registered result |
| zero_q | output | 1 | Registered flag: result is zero for a valid operation |
| invalid_q | output | 1 | Registered flag: no valid operation was requested |

## Verification
The ALU's rejection of reserved select codes is the hardest path to reach, because the decoder never passes a reserved code on purpose. The stimulus gets there by giving the decoder inputs that match no operation: the reserved class 3, and class 2 with unlisted function codes. The decoder then forwards a reserved code, and the ALU must refuse it. Signed comparison is driven with operands on both sides of the sign boundary, because there a signed and an unsigned compare give different answers. Additions that wrap to zero check that the zero flag follows the truncated 32-bit value rather than the full sum.

// File: rtl/alu_pkg.sv
package alu_pkg;
  // Internal operation select codes. The ALU decodes these values.
  typedef enum logic [2:0] {
    SEL_AND  = 3'b000,
    SEL_OR   = 3'b001,
    SEL_ADD  = 3'b010,
    SEL_RSV3 = 3'b011,
    SEL_RSV4 = 3'b100,
    SEL_RSV5 = 3'b101,
    SEL_SUB  = 3'b110,
    SEL_SLT  = 3'b111
  } op_sel_e;

  // Operation class from main control.
  typedef enum logic [1:0] {
    CLS_ADD  = 2'b00,
    CLS_SUB  = 2'b01,
    CLS_FUNC = 2'b10,
    CLS_RSV  = 2'b11
  } op_cls_e;

  localparam int FUNC_W = 6;
  localparam logic [FUNC_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FUNC_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FUNC_W-1:0] FN_AND = 6'b100100;
  localparam logic [FUNC_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FUNC_W-1:0] FN_SLT = 6'b101010;
endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
  import alu_pkg::*;
(
  input  logic [1:0]        cls,
  input  logic [FUNC_W-1:0] func,
  output op_sel_e           sel,
  output logic              bad
);
  always_comb begin
    sel = SEL_RSV3;
    bad = 1'b0;
    unique case (op_cls_e'(cls))
      CLS_ADD:  sel = SEL_ADD;
      CLS_SUB:  sel = SEL_SUB;
      CLS_FUNC: begin
        unique case (func)
          FN_ADD:  sel = SEL_ADD;
          FN_SUB:  sel = SEL_SUB;
          FN_AND:  sel = SEL_AND;
          FN_OR:   sel = SEL_OR;
          FN_SLT:  sel = SEL_SLT;
          default: begin sel = SEL_RSV3; bad = 1'b1; end
        endcase
      end
      default: begin sel = SEL_RSV3; bad = 1'b1; end
    endcase
  end

  // R8: a flagged decode must always hand the ALU a reserved code.
  always_comb begin
    if (bad) begin
      p_bad_gives_reserved_r8: assert (sel == SEL_RSV3 || sel == SEL_RSV4 || sel == SEL_RSV5);
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  op_sel_e           sel,
  output logic [DATA_W-1:0] y,
  output logic              inv
);
  logic [DATA_W-1:0] sum_w, dif_w;
  logic              lt_w;

  assign sum_w = a + b;
  assign dif_w = a - b;
  assign lt_w  = $signed(a) < $signed(b);

  always_comb begin
    y   = '0;
    inv = 1'b0;
    case (sel)
      SEL_AND: y = a & b;
      SEL_OR:  y = a | b;
      SEL_ADD: y = sum_w;
      SEL_SUB: y = dif_w;
      SEL_SLT: y = {{(DATA_W-1){1'b0}}, lt_w};
      default: begin y = '0; inv = 1'b1; end
    endcase
  end

  // R6: a compare result never has upper bits set.
  always_comb begin
    if (sel == SEL_SLT) begin
      p_slt_upper_clear_r6: assert (y[DATA_W-1:1] == '0);
    end
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        alu_class,
  input  logic [5:0]        func,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] res_q,
  output logic              zero_q,
  output logic              invalid_q
);
  op_sel_e           sel_w;
  logic              dec_bad_w;
  logic [DATA_W-1:0] y_w;
  logic              inv_w;

  alu_op_decoder u_dec (
    .cls  (alu_class),
    .func (func),
    .sel  (sel_w),
    .bad  (dec_bad_w)
  );

  alu_core #(.DATA_W(DATA_W)) u_core (
    .a   (opa),
    .b   (opb),
    .sel (sel_w),
    .y   (y_w),
    .inv (inv_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q     <= '0;
      zero_q    <= 1'b1;
      invalid_q <= 1'b0;
    end else begin
      res_q     <= y_w;
      zero_q    <= ~inv_w & (y_w == '0);
      invalid_q <= inv_w;
    end
  end

  // R7/R8: a rejected operation leaves a cleared result and no zero flag.
  p_invalid_clears_r7: assert property (@(posedge clk) disable iff (rst)
    invalid_q |-> (res_q == '0 && !zero_q));

  // R7: the reserved class is always reported as invalid.
  p_reserved_class_r7: assert property (@(posedge clk) disable iff (rst)
    (alu_class == 2'b11) |=> invalid_q);

  // R8: the decoder's rejection reaches the ALU's invalid flag.
  p_decode_reject_r8: assert property (@(posedge clk) disable iff (rst)
    dec_bad_w |-> inv_w);

  // R2: class 0 adds.
  p_class_add_r2: assert property (@(posedge clk) disable iff (rst)
    (alu_class == 2'b00) |=> (res_q == $past(opa) + $past(opb) && !invalid_q));

  // R9: the zero flag tracks a valid result.
  p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
    !invalid_q |-> (zero_q == (res_q == '0)));
endmodule

// File: tb/exu_alu_tb_top.sv
module exu_alu_tb_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    alu_class;
  logic [5:0]    func;
  logic [DW-1:0] opa, opb;
  logic [DW-1:0] res_q;
  logic          zero_q, invalid_q;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  exu_alu #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .alu_class(alu_class), .func(func),
    .opa(opa), .opb(opb), .res_q(res_q), .zero_q(zero_q), .invalid_q(invalid_q)
  );

  typedef struct packed {
    logic [7:0]    req;
    logic [1:0]    cls;
    logic [5:0]    fn;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    logic [DW-1:0] r;
    logic          z;
    logic          inv;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'd2,  2'b00, 6'b111111, 32'd10, 32'd7, 32'd17, 1'b0, 1'b0},          // R2 func ignored
    '{8'd3,  2'b01, 6'b100000, 32'd10, 32'd7, 32'd3,  1'b0, 1'b0},          // R3 func ignored
    '{8'd4,  2'b10, 6'b100000, 32'd10, 32'd7, 32'd17, 1'b0, 1'b0},          // R4 add
    '{8'd4,  2'b10, 6'b100010, 32'd10, 32'd7, 32'd3,  1'b0, 1'b0},          // R4 sub
    '{8'd5,  2'b10, 6'b100100, 32'd10, 32'd7, 32'd2,  1'b0, 1'b0},          // R5 and
    '{8'd5,  2'b10, 6'b100101, 32'd10, 32'd7, 32'd15, 1'b0, 1'b0},          // R5 or
    '{8'd6,  2'b10, 6'b101010, 32'd10, 32'd7, 32'd0,  1'b1, 1'b0},          // R6 not less
    '{8'd6,  2'b10, 6'b101010, 32'hFFFF_FFFF, 32'd1, 32'd1, 1'b0, 1'b0},    // R6 signed -1 < 1
    '{8'd6,  2'b10, 6'b101010, 32'd1, 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b0},    // R6 signed 1 > -1
    '{8'd6,  2'b10, 6'b101010, 32'h8000_0000, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0}, // R6 extremes
    '{8'd7,  2'b11, 6'b100000, 32'd10, 32'd7, 32'd0,  1'b0, 1'b1},          // R7 reserved class
    '{8'd7,  2'b11, 6'b000000, 32'd0,  32'd0, 32'd0,  1'b0, 1'b1},          // R7 zero operands
    '{8'd8,  2'b10, 6'b000000, 32'd10, 32'd7, 32'd0,  1'b0, 1'b1},          // R8 unlisted func
    '{8'd8,  2'b10, 6'b100001, 32'd10, 32'd7, 32'd0,  1'b0, 1'b1},          // R8 near-miss func
    '{8'd9,  2'b10, 6'b100000, 32'hFFFF_FFFF, 32'd1, 32'd0, 1'b1, 1'b0},    // R9 wrap to zero
    '{8'd9,  2'b01, 6'b000000, 32'd5, 32'd5, 32'd0, 1'b1, 1'b0}             // R9 equal subtract
  };

  task automatic check(input string tag, input logic [DW-1:0] r, input logic z, input logic inv);
    checks++;
    if (res_q !== r || zero_q !== z || invalid_q !== inv) begin
      errors++;
      $display("FAIL %s: got res=%h zero=%b inv=%b, expected res=%h zero=%b inv=%b",
               tag, res_q, zero_q, invalid_q, r, z, inv);
    end
  endtask

  task automatic apply(input logic [1:0] c, input logic [5:0] f,
                       input logic [DW-1:0] a, input logic [DW-1:0] b);
    @(negedge clk);
    alu_class = c; func = f; opa = a; opb = b;
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; alu_class = 2'b00; func = '0; opa = 32'd3; opb = 32'd4;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset state", 32'd0, 1'b1, 1'b0);

    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].cls, VECS[i].fn, VECS[i].a, VECS[i].b);
      checks++;
      if (res_q !== VECS[i].r || zero_q !== VECS[i].z || invalid_q !== VECS[i].inv) begin
        errors++;
        $display("FAIL R%0d vector %0d: got res=%h zero=%b inv=%b, expected res=%h zero=%b inv=%b",
                 VECS[i].req, i, res_q, zero_q, invalid_q, VECS[i].r, VECS[i].z, VECS[i].inv);
      end
    end

    // R10: inputs changed mid-cycle do not show until the next edge.
    apply(2'b00, 6'b0, 32'd20, 32'd22);
    check("R10 first sample", 32'd42, 1'b0, 1'b0);
    @(negedge clk);
    alu_class = 2'b11; opa = 32'd1; opb = 32'd1;
    #2;
    check("R10 held between edges", 32'd42, 1'b0, 1'b0);
    @(posedge clk);
    #1;
    check("R10 updated at edge", 32'd0, 1'b0, 1'b1);

    // R1: reset after an invalid result clears the flag.
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 reset after invalid", 32'd0, 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R5: OR and AND on wide patterns.
    apply(2'b10, 6'b100101, 32'hF0F0_0000, 32'h0000_0F0F);
    check("R5 wide or", 32'hF0F0_0F0F, 1'b0, 1'b0);
    apply(2'b10, 6'b100100, 32'hF0F0_0000, 32'h0000_0F0F);
    check("R5 disjoint and", 32'd0, 1'b1, 1'b0);

    // R3: subtract underflow wraps.
    apply(2'b01, 6'b101010, 32'd0, 32'd1);
    check("R3 underflow", 32'hFFFF_FFFF, 1'b0, 1'b0);

    // R9: add of two sign bits wraps to zero.
    apply(2'b00, 6'b000000, 32'h8000_0000, 32'h8000_0000);
    check("R9 sign carry out", 32'd0, 1'b1, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule